// File: doc/BRIEF.md
# Write-Combining Store Gather Buffer

This block gathers stores that missed the first-level cache into a small pool of line-sized combining buffers. Each buffer remembers a line tag, a cacheability flag, the line's data bytes and a mask marking which bytes have been written. Later stores to the same line fold into the same buffer, and at the same byte offset the newer byte replaces the older one. Nothing leaves the block for a line until its buffer is told to drain.

Draining depends on the line. A cacheable line whose mask is incomplete first sends an ownership read. When the read data returns, it fills only the bytes no store touched, and the whole line then goes out as one full-line write. A cacheable line whose mask is already complete skips the read and goes out at once. An uncached line never reads: its gathered bytes go out as a single write that carries the byte mask.

A buffer drains when its mask fills, when a new line needs a buffer and none is free (the oldest is forced out), or during a flush. At most two buffers are in their drain phase at any time. A flush stalls new stores, drains every open buffer from oldest to newest, and pulses a done flag once the pool is empty.

Top module: `wcomb_buffer`

## Requirements
- R1: After reset, no buffer is open: `rfo_valid`, `drn_valid` and `flush_done` are 0 and `st_ready` is 1.
- R2: Stores to a line that has an open buffer merge into that buffer. A later byte at the same offset overwrites an earlier one. No ownership read is issued while the buffer stays open. Store lane k of word w lands in line byte w*ST_BYTES+k. Line byte b occupies data bits [8b+7:8b].
- R3: A store to a line with no buffer allocates a free buffer in the same cycle it is presented. A store that hits an open buffer is also accepted in that cycle. No two open buffers ever hold the same line.
- R4: When a store misses, no buffer is free and no buffer is draining, `st_ready` stays 0 and the oldest open buffer (by allocation order) is forced to drain. The store is accepted once a buffer frees.
- R5: A draining cacheable buffer with an incomplete mask issues one ownership read carrying `rfo_line` and `rfo_id`. A response with a matching `rsp_id` is merged: stored bytes are kept and every other byte comes from `rsp_data`. The line then leaves on the drain port with `drn_mask` all ones and `drn_uc` 0.
- R6: A cacheable buffer whose mask becomes all ones drains by itself, with no flush and no ownership read, and carries exactly the stored bytes.
- R7: An uncached buffer never issues an ownership read. It drains with `drn_uc` 1 and `drn_mask` equal to the set of bytes written.
- R8: No more than MAX_DRAIN (default 2) buffers are between leaving the open state and acceptance of their drain. Any further buffers stay open and issue no ownership read.
- R9: A `flush_req` pulse stalls all stores and starts the open buffers draining, oldest first. `flush_done` is high for one cycle once every buffer is free.
- R10: A store to the line of a buffer that is draining stalls until that drain is accepted. The store then goes into a fresh buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store accepted this cycle |
| st_line | input | TAG_W | Line address of the store |
| st_word | input | WORD_W | Word index within the line |
| st_data | input | ST_BYTES*8 | Store data |
| st_be | input | ST_BYTES | Store byte enables |
| st_uc | input | 1 | Store targets an uncached line |
| flush_req | input | 1 | Pulse: drain all buffers |
| flush_done | output | 1 | One-cycle pulse: all buffers empty after a flush |
| rfo_valid | output | 1 | Ownership read request |
| rfo_ready | input | 1 | Ownership read accepted |
| rfo_line | output | TAG_W | Line being read |
| rfo_id | output | IDX_W | Buffer index to return with the response |
| rsp_valid | input | 1 | Ownership read data returning |
| rsp_id | input | IDX_W | Buffer index of the response |
| rsp_data | input | LINE_BYTES*8 | Returned line |
| drn_valid | output | 1 | Line write presented |
| drn_ready | input | 1 | Line write accepted |
| drn_line | output | TAG_W | Line address of the write |
| drn_data | output | LINE_BYTES*8 | Line data |
| drn_mask | output | LINE_BYTES | Bytes to write |
| drn_uc | output | 1 | Write targets an uncached line |

## Verification
On every cycle, the checker enforces the drain-slot limit, the rule that only one open buffer can match an incoming line, the absence of ownership reads for uncached lines, full masks on cacheable line writes, ownership requests held until accepted, and a quiet request interface when the flush completes. Only the bench's scenarios can show the things that depend on a store history. These are byte overwrite and merge under the fetched line, the choice of the oldest buffer for forced and flush drains, the stall on a line that is draining, and the self-drain of a completed line. The bench sweeps every byte-enable pattern into one line and checks each line write against a model that computes the fetched bytes arithmetically.

// File: rtl/wcb_pkg.sv
// Shared types for the write-combining buffer pool.
package wcb_pkg;
    // Life cycle of one combining buffer.
    typedef enum logic [2:0] {
        WB_FREE     = 3'd0,
        WB_OPEN     = 3'd1,
        WB_RFO_REQ  = 3'd2,
        WB_RFO_WAIT = 3'd3,
        WB_WRITE    = 3'd4
    } wb_state_t;
endpackage

// File: rtl/wcb_lowest.sv
// Fixed-priority picker: returns the lowest set index of a request vector.
// Assumes N >= 1; idx is meaningful only while valid is high.
module wcb_lowest #(
    parameter int N = 6,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest requester wins.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wcb_oldest.sv
// Oldest picker: among candidate buffers returns the one with the largest age rank.
// Assumes ranks of candidates are distinct (kept so by the entries).
module wcb_oldest #(
    parameter int N = 6,
    parameter int AGE_W = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       cand,
    input  logic [N*AGE_W-1:0] ages,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    logic [AGE_W-1:0] best;

    // Linear maximum search over the candidate ranks.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!valid || ages[i*AGE_W +: AGE_W] > best)) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
                best  = ages[i*AGE_W +: AGE_W];
            end
        end
    end
endmodule

// File: rtl/wcb_entry.sv
// One combining buffer: tag, cacheability, line data, byte mask, age rank and
// drain state. Assumes the parent issues at most one of alloc/merge per cycle,
// go only while OPEN, fill only while RFO_WAIT, and drn_sent only while WRITE.
module wcb_entry
    import wcb_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int ST_BYTES   = 8,
    parameter int TAG_W      = 26,
    parameter int AGE_W      = 3,
    localparam int NWORD  = LINE_BYTES / ST_BYTES,
    localparam int WORD_W = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int ST_W   = ST_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic                  merge,
    input  logic                  go,
    input  logic                  rfo_sent,
    input  logic                  fill,
    input  logic                  drn_sent,
    input  logic [TAG_W-1:0]      st_line,
    input  logic                  st_uc,
    input  logic [WORD_W-1:0]     st_word,
    input  logic [ST_W-1:0]       st_data,
    input  logic [ST_BYTES-1:0]   st_be,
    input  logic [LINE_W-1:0]     fill_data,
    input  logic                  alloc_any,
    input  logic                  leave_any,
    input  logic [AGE_W-1:0]      leave_age,
    output wb_state_t             state,
    output logic [TAG_W-1:0]      tag,
    output logic                  uc,
    output logic                  full,
    output logic [AGE_W-1:0]      age,
    output logic [LINE_W-1:0]     data,
    output logic [LINE_BYTES-1:0] mask
);
    logic [LINE_BYTES-1:0] byte_we;

    assign full = &mask;

    // Per-byte write enable, data and mask storage.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        localparam int WI = b / ST_BYTES;
        localparam int LN = b % ST_BYTES;

        assign byte_we[b] = (alloc || merge) && (st_word == WORD_W'(WI)) && st_be[LN];

        // Store bytes win; fetched bytes fill only unwritten positions.
        always_ff @(posedge clk) begin
            if (byte_we[b])
                data[b*8 +: 8] <= st_data[LN*8 +: 8];
            else if (fill && !mask[b])
                data[b*8 +: 8] <= fill_data[b*8 +: 8];
        end

        // Mask clears on drain, completes on fill, accumulates on store.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[b] <= 1'b0;
            else if (drn_sent)
                mask[b] <= 1'b0;
            else if (fill || byte_we[b])
                mask[b] <= 1'b1;
        end
    end

    // Buffer life-cycle sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WB_FREE;
        end else begin
            case (state)
                WB_FREE:     if (alloc)    state <= WB_OPEN;
                WB_OPEN:     if (go)       state <= (uc || full) ? WB_WRITE : WB_RFO_REQ;
                WB_RFO_REQ:  if (rfo_sent) state <= WB_RFO_WAIT;
                WB_RFO_WAIT: if (fill)     state <= WB_WRITE;
                WB_WRITE:    if (drn_sent) state <= WB_FREE;
                default:                   state <= WB_FREE;
            endcase
        end
    end

    // Line identity captured at allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
            uc  <= 1'b0;
        end else if (alloc) begin
            tag <= st_line;
            uc  <= st_uc;
        end
    end

    // Age rank: 0 for the newest open buffer, ranks stay dense as buffers come and go.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (alloc)
            age <= '0;
        else if (state == WB_OPEN)
            age <= age + AGE_W'(alloc_any) - AGE_W'(leave_any && (age > leave_age));
    end
endmodule

// File: rtl/wcomb_buffer.sv
// Write-combining store gather buffer pool (top).
// Gathers missed stores per line, drains by ownership read plus merge for
// cacheable lines or by masked write for uncached lines, limits concurrent
// drains, and supports a whole-pool flush. Assumes a given line is always
// presented with the same cacheability, and that rsp_id only names a buffer
// with an ownership read outstanding.
module wcomb_buffer
    import wcb_pkg::*;
#(
    parameter int NUM_BUF    = 6,
    parameter int LINE_BYTES = 64,
    parameter int ST_BYTES   = 8,
    parameter int TAG_W      = 26,
    parameter int MAX_DRAIN  = 2,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int NWORD  = LINE_BYTES / ST_BYTES,
    localparam int WORD_W = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int ST_W   = ST_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [TAG_W-1:0]      st_line,
    input  logic [WORD_W-1:0]     st_word,
    input  logic [ST_W-1:0]       st_data,
    input  logic [ST_BYTES-1:0]   st_be,
    input  logic                  st_uc,
    input  logic                  flush_req,
    output logic                  flush_done,
    output logic                  rfo_valid,
    input  logic                  rfo_ready,
    output logic [TAG_W-1:0]      rfo_line,
    output logic [IDX_W-1:0]      rfo_id,
    input  logic                  rsp_valid,
    input  logic [IDX_W-1:0]      rsp_id,
    input  logic [LINE_W-1:0]     rsp_data,
    output logic                  drn_valid,
    input  logic                  drn_ready,
    output logic [TAG_W-1:0]      drn_line,
    output logic [LINE_W-1:0]     drn_data,
    output logic [LINE_BYTES-1:0] drn_mask,
    output logic                  drn_uc
);
    wb_state_t             ent_state [NUM_BUF];
    logic [TAG_W-1:0]      ent_tag   [NUM_BUF];
    logic [IDX_W-1:0]      ent_age   [NUM_BUF];
    logic [LINE_W-1:0]     ent_data  [NUM_BUF];
    logic [LINE_BYTES-1:0] ent_mask  [NUM_BUF];
    logic [NUM_BUF-1:0]    ent_uc, ent_full;
    logic [NUM_BUF*IDX_W-1:0] age_flat;

    logic [NUM_BUF-1:0] is_free, is_open, is_rfoq, is_write, draining;
    logic [NUM_BUF-1:0] hit_open, hit_busy, full_open;

    logic             any_free, hit_any, full_any, old_any, rfo_any, drn_any;
    logic [IDX_W-1:0] free_idx, hit_idx, full_idx, old_idx, drn_idx;
    logic             flush_active, st_miss, force_drain, want_oldest, slot_ok;
    logic             leave_go, merge_go, alloc_go, rfo_sel_uc;
    logic [IDX_W-1:0] leave_idx;

    // Buffer array with per-entry command decode.
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_ent
        wcb_entry #(
            .LINE_BYTES(LINE_BYTES), .ST_BYTES(ST_BYTES), .TAG_W(TAG_W), .AGE_W(IDX_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_go && free_idx == IDX_W'(i)),
            .merge     (merge_go && hit_idx == IDX_W'(i)),
            .go        (leave_go && leave_idx == IDX_W'(i)),
            .rfo_sent  (rfo_valid && rfo_ready && rfo_id == IDX_W'(i)),
            .fill      (rsp_valid && rsp_id == IDX_W'(i) && ent_state[i] == WB_RFO_WAIT),
            .drn_sent  (drn_valid && drn_ready && drn_idx == IDX_W'(i)),
            .st_line   (st_line),
            .st_uc     (st_uc),
            .st_word   (st_word),
            .st_data   (st_data),
            .st_be     (st_be),
            .fill_data (rsp_data),
            .alloc_any (alloc_go),
            .leave_any (leave_go),
            .leave_age (ent_age[leave_idx]),
            .state     (ent_state[i]),
            .tag       (ent_tag[i]),
            .uc        (ent_uc[i]),
            .full      (ent_full[i]),
            .age       (ent_age[i]),
            .data      (ent_data[i]),
            .mask      (ent_mask[i])
        );

        assign age_flat[i*IDX_W +: IDX_W] = ent_age[i];
        assign is_free[i]   = ent_state[i] == WB_FREE;
        assign is_open[i]   = ent_state[i] == WB_OPEN;
        assign is_rfoq[i]   = ent_state[i] == WB_RFO_REQ;
        assign is_write[i]  = ent_state[i] == WB_WRITE;
        assign draining[i]  = !is_free[i] && !is_open[i];
        assign hit_open[i]  = is_open[i] && ent_tag[i] == st_line;
        assign hit_busy[i]  = draining[i] && ent_tag[i] == st_line;
        assign full_open[i] = is_open[i] && ent_full[i];
    end

    wcb_lowest #(.N(NUM_BUF)) u_pick_free  (.req(is_free),   .valid(any_free), .idx(free_idx));
    wcb_lowest #(.N(NUM_BUF)) u_pick_hit   (.req(hit_open),  .valid(hit_any),  .idx(hit_idx));
    wcb_lowest #(.N(NUM_BUF)) u_pick_full  (.req(full_open), .valid(full_any), .idx(full_idx));
    wcb_lowest #(.N(NUM_BUF)) u_pick_rfo   (.req(is_rfoq),   .valid(rfo_any),  .idx(rfo_id));
    wcb_lowest #(.N(NUM_BUF)) u_pick_drain (.req(is_write),  .valid(drn_any),  .idx(drn_idx));
    wcb_oldest #(.N(NUM_BUF), .AGE_W(IDX_W)) u_pick_old (
        .cand(is_open), .ages(age_flat), .valid(old_any), .idx(old_idx)
    );

    // Drain scheduling: oldest first under flush or pressure, otherwise completed lines.
    always_comb begin
        st_miss     = !hit_any && !(|hit_busy);
        force_drain = st_valid && st_miss && !any_free && !(|draining);
        want_oldest = flush_active || force_drain;
        slot_ok     = $countones(draining) < MAX_DRAIN;
        leave_go    = slot_ok && (want_oldest ? old_any : full_any);
        leave_idx   = want_oldest ? old_idx : full_idx;
    end

    // Store acceptance: merge into an open buffer that is not leaving, or allocate.
    always_comb begin
        st_ready = !flush_active &&
                   ((hit_any && !(leave_go && leave_idx == hit_idx)) || (st_miss && any_free));
        merge_go = st_valid && st_ready && hit_any;
        alloc_go = st_valid && st_ready && st_miss;
    end

    // Flush tracking from request pulse until the pool is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_active <= 1'b0;
        else if (flush_done)
            flush_active <= 1'b0;
        else if (flush_req)
            flush_active <= 1'b1;
    end

    assign flush_done = flush_active && (&is_free);

    // Memory-side outputs steered from the picked buffers.
    assign rfo_valid  = rfo_any;
    assign rfo_line   = ent_tag[rfo_id];
    assign rfo_sel_uc = ent_uc[rfo_id];
    assign drn_valid  = drn_any;
    assign drn_line   = ent_tag[drn_idx];
    assign drn_data   = ent_data[drn_idx];
    assign drn_mask   = ent_mask[drn_idx];
    assign drn_uc     = ent_uc[drn_idx];
endmodule

// File: rtl/wcomb_buffer_chk.sv
// Cycle-level property checker for wcomb_buffer, bound into every instance.
module wcomb_buffer_chk #(
    parameter int NUM_BUF    = 6,
    parameter int LINE_BYTES = 64,
    parameter int MAX_DRAIN  = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_BUF-1:0]    draining,
    input logic [NUM_BUF-1:0]    hit_open,
    input logic                  rfo_valid,
    input logic                  rfo_ready,
    input logic                  rfo_sel_uc,
    input logic                  drn_valid,
    input logic                  drn_uc,
    input logic [LINE_BYTES-1:0] drn_mask,
    input logic                  flush_done
);
    // R8: never more buffers in their drain phase than slots.
    assert_drain_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(draining) <= MAX_DRAIN);

    // R3: an incoming line matches at most one open buffer.
    assert_single_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_open));

    // R7: an uncached buffer never asks for ownership.
    assert_no_uc_rfo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rfo_valid |-> !rfo_sel_uc);

    // R5: cacheable lines always leave as a complete line.
    assert_full_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_valid && !drn_uc) |-> (&drn_mask));

    // R5: an ownership request stays up until accepted.
    assert_rfo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rfo_valid && !rfo_ready) |=> rfo_valid);

    // R9: a finished flush leaves nothing pending at the memory side.
    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (!rfo_valid && !drn_valid));
endmodule

bind wcomb_buffer wcomb_buffer_chk #(
    .NUM_BUF(NUM_BUF), .LINE_BYTES(LINE_BYTES), .MAX_DRAIN(MAX_DRAIN)
) u_chk (.*);

// File: tb/wcomb_buffer_bench.sv
`timescale 1ns/1ps
// Self-checking bench for wcomb_buffer on a small configuration (16-byte lines).
module wcomb_buffer_bench;
    localparam int NB = 6;
    localparam int LB = 16;
    localparam int SB = 4;
    localparam int TW = 8;
    localparam int LW = LB * 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [TW-1:0] st_line = '0;
    logic [1:0]    st_word = '0;
    logic [31:0]   st_data = '0;
    logic [SB-1:0] st_be = '0;
    logic          st_uc = 1'b0;
    logic          flush_req = 1'b0;
    logic          flush_done;
    logic          rfo_valid;
    logic          rfo_ready = 1'b1;
    logic [TW-1:0] rfo_line;
    logic [IW-1:0] rfo_id;
    logic          rsp_valid = 1'b0;
    logic [IW-1:0] rsp_id = '0;
    logic [LW-1:0] rsp_data = '0;
    logic          drn_valid;
    logic          drn_ready = 1'b1;
    logic [TW-1:0] drn_line;
    logic [LW-1:0] drn_data;
    logic [LB-1:0] drn_mask;
    logic          drn_uc;

    int nchk = 0;
    int nfail = 0;
    int rfo_cnt = 0;
    int drn_cnt = 0;
    int flush_cnt = 0;
    logic [TW-1:0] rfo_log [64];
    logic [LW-1:0] exp_data [256];
    logic [LB-1:0] exp_mask [256];
    logic          exp_uc   [256];
    logic [TW-1:0] q_line [8];
    logic [IW-1:0] q_id   [8];
    int q_cnt = 0;

    always #4 clk = ~clk;

    wcomb_buffer #(
        .NUM_BUF(NB), .LINE_BYTES(LB), .ST_BYTES(SB), .TAG_W(TW), .MAX_DRAIN(2)
    ) u_wcomb_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line), .st_word(st_word),
        .st_data(st_data), .st_be(st_be), .st_uc(st_uc),
        .flush_req(flush_req), .flush_done(flush_done),
        .rfo_valid(rfo_valid), .rfo_ready(rfo_ready), .rfo_line(rfo_line), .rfo_id(rfo_id),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_line(drn_line),
        .drn_data(drn_data), .drn_mask(drn_mask), .drn_uc(drn_uc)
    );

    // Memory content of a line, computed arithmetically.
    function automatic logic [LW-1:0] memline(input logic [TW-1:0] line);
        logic [LW-1:0] v;
        for (int b = 0; b < LB; b++) v[b*8 +: 8] = 8'(int'(line) * 7 + b * 13 + 60);
        return v;
    endfunction

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare one accepted line write with the model, then retire the line.
    task automatic check_drain();
        logic [LB-1:0] mexp;
        logic [LW-1:0] dexp, bm, mem;
        string tag;
        mem = memline(drn_line);
        mexp = exp_uc[drn_line] ? exp_mask[drn_line] : '1;
        tag = exp_uc[drn_line] ? "R7 uncached write" :
              (&exp_mask[drn_line]) ? "R6 full line write" : "R5 merged line write";
        for (int b = 0; b < LB; b++) begin
            dexp[b*8 +: 8] = exp_mask[drn_line][b] ? exp_data[drn_line][b*8 +: 8] : mem[b*8 +: 8];
            bm[b*8 +: 8]   = mexp[b] ? 8'hFF : 8'h00;
        end
        chk({tag, " line had stores"}, LW'(exp_mask[drn_line] != '0), LW'(1));
        chk({tag, " mask"}, LW'(drn_mask), LW'(mexp));
        chk({tag, " data"}, drn_data & bm, dexp & bm);
        chk({tag, " uc flag"}, LW'(drn_uc), LW'(exp_uc[drn_line]));
        exp_mask[drn_line] = '0;
        drn_cnt++;
    endtask

    // Memory responder and port monitor, all away from the active edge.
    always @(negedge clk) begin
        if (q_cnt > 0) begin
            rsp_valid = 1'b1;
            rsp_id    = q_id[0];
            rsp_data  = memline(q_line[0]);
            for (int k = 0; k < 7; k++) begin
                q_id[k]   = q_id[k+1];
                q_line[k] = q_line[k+1];
            end
            q_cnt--;
        end else begin
            rsp_valid = 1'b0;
        end
        #2;
        if (rst_n) begin
            if (rfo_valid && rfo_ready) begin
                chk("R6/R7 no ownership read for full or uncached line",
                    LW'(exp_uc[rfo_line] || (&exp_mask[rfo_line])), LW'(0));
                rfo_log[rfo_cnt % 64] = rfo_line;
                rfo_cnt++;
                q_line[q_cnt] = rfo_line;
                q_id[q_cnt]   = rfo_id;
                q_cnt++;
            end
            if (drn_valid && drn_ready) check_drain();
            if (flush_done) flush_cnt++;
        end
    end

    // Called at negedge+2 with a store presented: wait for acceptance, update model.
    task automatic wait_accept(output int stalls);
        stalls = 0;
        while (!st_ready) begin
            @(negedge clk);
            #2;
            stalls++;
        end
        for (int k = 0; k < SB; k++) begin
            if (st_be[k]) begin
                exp_data[st_line][(int'(st_word) * SB + k) * 8 +: 8] = st_data[k*8 +: 8];
                exp_mask[st_line][int'(st_word) * SB + k] = 1'b1;
            end
        end
        exp_uc[st_line] = st_uc;
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic present(input logic [TW-1:0] line, input int w, input logic [31:0] d,
                           input logic [SB-1:0] be, input logic uc);
        st_valid = 1'b1;
        st_line  = line;
        st_word  = 2'(w);
        st_data  = d;
        st_be    = be;
        st_uc    = uc;
    endtask

    task automatic do_store(input logic [TW-1:0] line, input int w, input logic [31:0] d,
                            input logic [SB-1:0] be, input logic uc, output int stalls);
        @(negedge clk);
        present(line, w, d, be, uc);
        #2;
        wait_accept(stalls);
    endtask

    task automatic do_flush();
        int n0;
        n0 = flush_cnt;
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        for (int c = 0; c < 3000 && flush_cnt == n0; c++) @(negedge clk);
        #3;
        chk("R9 flush completes with done pulse", LW'(flush_cnt), LW'(n0 + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        int s, base, d0;
        for (int i = 0; i < 256; i++) begin
            exp_mask[i] = '0;
            exp_uc[i] = 1'b0;
            exp_data[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1 st_ready after reset", LW'(st_ready), LW'(1));
        chk("R1 rfo_valid after reset", LW'(rfo_valid), LW'(0));
        chk("R1 drn_valid after reset", LW'(drn_valid), LW'(0));
        chk("R1 flush_done after reset", LW'(flush_done), LW'(0));

        // R2/R5: every byte-enable pattern on words 0..2 of one line, with overwrites
        for (int w = 0; w < 3; w++)
            for (int be = 1; be < 16; be++)
                do_store(8'h11, w, 32'(w * 4099 + be * 257) ^ 32'hA5C3_1E77, 4'(be), 1'b0, s);
        chk("R2 no ownership read while gathering", LW'(rfo_cnt), LW'(0));
        chk("R2 no write while gathering", LW'(drn_cnt), LW'(0));
        do_flush();
        chk("R5 one ownership read for partial line", LW'(rfo_cnt), LW'(1));
        chk("R5 ownership read line", LW'(rfo_log[0]), LW'(8'h11));
        chk("R5 one line write", LW'(drn_cnt), LW'(1));

        // R6: line completed by complementary halves drains by itself
        for (int w = 0; w < 4; w++) begin
            do_store(8'h22, w, 32'h1111_1111 * (w + 1), 4'b0101, 1'b0, s);
            do_store(8'h22, w, 32'h2222_2222 * (w + 1), 4'b1010, 1'b0, s);
        end
        for (int c = 0; c < 20 && drn_cnt < 2; c++) @(negedge clk);
        #3;
        chk("R6 full line drained without flush", LW'(drn_cnt), LW'(2));
        chk("R6 no ownership read for full line", LW'(rfo_cnt), LW'(1));

        // R7: uncached partial line with an overwrite
        do_store(8'h33, 1, 32'hDEAD_BEEF, 4'b1001, 1'b1, s);
        do_store(8'h33, 3, 32'h0BAD_F00D, 4'b0110, 1'b1, s);
        do_store(8'h33, 1, 32'h5555_AA11, 4'b0011, 1'b1, s);
        do_flush();
        chk("R7 uncached line written once", LW'(drn_cnt), LW'(3));
        chk("R7 uncached line never reads", LW'(rfo_cnt), LW'(1));

        // R3: six new lines allocate without stall, a hit merges without stall
        for (int i = 0; i < NB; i++) begin
            do_store(8'h40 + 8'(i), 0, 32'h0000_0010 + 32'(i), 4'b0001, 1'b0, s);
            chk("R3 allocation without stall", LW'(s), LW'(0));
        end
        do_store(8'h42, 2, 32'h7777_7777, 4'b1100, 1'b0, s);
        chk("R3 hit merges without stall", LW'(s), LW'(0));

        // R4: seventh line stalls and forces the oldest buffer out
        base = rfo_cnt;
        @(negedge clk);
        present(8'h46, 1, 32'hCAFE_0046, 4'b0010, 1'b0);
        #2;
        chk("R4 store stalls with no free buffer", LW'(st_ready), LW'(0));
        wait_accept(s);
        chk("R4 exactly one forced drain", LW'(rfo_cnt), LW'(base + 1));
        chk("R4 forced drain picks oldest line", LW'(rfo_log[base % 64]), LW'(8'h40));
        do_flush();
        for (int i = 1; i < NB + 1; i++)
            chk("R9 flush drains in allocation order",
                LW'(rfo_log[(base + i) % 64]), LW'(8'h40 + 8'(i)));
        chk("R9 flush drains all lines", LW'(drn_cnt), LW'(3 + 7));

        // R8: with writes blocked, only two buffers enter their drain phase
        drn_ready = 1'b0;
        base = rfo_cnt;
        d0 = drn_cnt;
        for (int i = 0; i < 4; i++)
            do_store(8'h50 + 8'(i), 3, 32'h00C0_FFEE + 32'(i), 4'b0100, 1'b0, s);
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        repeat (30) @(negedge clk);
        #2;
        chk("R8 only two ownership reads while blocked", LW'(rfo_cnt), LW'(base + 2));
        present(8'h60, 0, 32'h1234_5678, 4'b1111, 1'b0);
        #1;
        chk("R9 stores stall during flush", LW'(st_ready), LW'(0));
        st_valid = 1'b0;
        @(negedge clk);
        drn_ready = 1'b1;
        s = flush_cnt;
        for (int c = 0; c < 3000 && flush_cnt == s; c++) @(negedge clk);
        #3;
        chk("R9 flush done after release", LW'(flush_cnt), LW'(s + 1));
        chk("R8 remaining reads after release", LW'(rfo_cnt), LW'(base + 4));
        chk("R8 all four written", LW'(drn_cnt), LW'(d0 + 4));

        // R10: store to a line stuck in its write phase stalls, then reopens fresh
        drn_ready = 1'b0;
        d0 = drn_cnt;
        for (int w = 0; w < 4; w++)
            do_store(8'h70, w, 32'h7070_0000 + 32'(w), 4'b1111, 1'b0, s);
        repeat (5) @(negedge clk);
        present(8'h70, 0, 32'h0000_00AB, 4'b0001, 1'b0);
        #2;
        chk("R10 store to draining line stalls", LW'(st_ready), LW'(0));
        @(negedge clk);
        drn_ready = 1'b1;
        #2;
        wait_accept(s);
        chk("R10 first write completed before reopen", LW'(drn_cnt), LW'(d0 + 1));
        do_flush();
        chk("R10 reopened line written separately", LW'(drn_cnt), LW'(d0 + 2));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule